// File: doc/BRIEF.md
# Combinational Modulo-m Residue Multiplier

This block multiplies two residues of one fixed modulus and returns their product reduced by that modulus, with no clock and no storage. The modulus is chosen when the block is elaborated. Both operands and the result are n bits wide, where n = floor(log2 m) + 1. Only the values 0 to m-1 are legal on either operand. For any larger operand value the result is left undefined.

The datapath has three stages. The mapping stage forms every bit product a_i·b_j and drops it into each result column in which the binary form of (2^(i+j) mod m) has a one. Inside one column, bit products that cannot be high together for any legal operand pair are merged by a single OR gate, which needs no carry. The other bit products each enter the column adder on their own. The folding stage then repeats a modular fold as many times as needed. Each fold keeps the low n bits and maps every higher bit back through its reduced weight, until the value is known to be below 2m. The correcting stage subtracts m once if the value is m or more. The elaboration-time functions work out the groups of exclusive bits, the bound and width of each intermediate value, and the number of folds.

Top module: `resmul_core`

## Requirements
- R1: Operands and result are n = floor(log2 m)+1 bits wide. The result is correct when either operand takes the largest legal value m-1.
- R2: For every legal pair (a, b) with both values below m, the output c_o equals (a·b) mod m.
- R3: For legal operands the output is always below m.
- R4: If either operand is 0, the output is 0.
- R5: If either operand is 1, the output equals the other operand.
- R6: A bit product whose reduced weight has several set bits is added into each of those columns. For m = 5, a = 2 and b = 4 give 3.
- R7: With both operands equal to m-1 the output is 1, for any modulus above 1.
- R8: A modulus one below a power of two is reduced correctly. For m = 31, every legal pair matches (a·b) mod 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | n | First residue operand, legal range 0 to m-1 |
| b_i | input | n | Second residue operand, legal range 0 to m-1 |
| c_o | output | n | Product of the operands reduced modulo m |

## Verification
The hardest case to reach is a column where an OR merge is only safe because some operand values never occur. The merge would give a wrong sum only if two merged bit products were high together, so a design fault there shows up only for a few operand pairs near m-1. The stimulus therefore sweeps every legal pair for four moduli: 5, 13, 31 and 61. These moduli give different merge patterns and different fold counts, and each product is checked against an arithmetic model in the bench.

// File: rtl/resmul_pkg.sv
package resmul_pkg;

    localparam int MAX_W = 8;
    localparam int MAX_P = MAX_W * MAX_W;

    function automatic int op_width(int m);
        return $clog2(m + 1);
    endfunction

    // 2^e reduced modulo m
    function automatic int wmod(int m, int e);
        int r;
        r = 1 % m;
        for (int k = 0; k < e; k++) r = (r * 2) % m;
        return r;
    endfunction

    // bit i*MAX_W+k set when some legal operand has bits i and k both high
    function automatic logic [MAX_P-1:0] coex_mask(int m, int n);
        logic [MAX_P-1:0] r;
        r = '0;
        for (int v = 0; v < m; v++)
            for (int i = 0; i < n; i++)
                for (int k = 0; k < n; k++)
                    if ((((v >> i) & 1) == 1) && (((v >> k) & 1) == 1)) r[i*MAX_W+k] = 1'b1;
        return r;
    endfunction

    function automatic bit col_has(int m, int n, int c, int q);
        return ((wmod(m, (q / n) + (q % n)) >> c) & 1) == 1;
    endfunction

    function automatic bit exclusive(int n, logic [MAX_P-1:0] coex, int r, int q);
        int i, j, k, l;
        i = r / n; j = r % n; k = q / n; l = q % n;
        return !(coex[i*MAX_W+k] && coex[j*MAX_W+l]);
    endfunction

    // greedy grouping of pairwise exclusive bit products (at most 3) in column c;
    // returns the member mask of the group led by product p, zero if p leads none
    function automatic logic [MAX_P-1:0] members(int m, int n, logic [MAX_P-1:0] coex, int c, int p);
        int ld [MAX_P];
        int sz [MAX_P];
        bit placed, ok;
        logic [MAX_P-1:0] r;
        for (int q = 0; q < n * n; q++) begin
            ld[q] = -1;
            sz[q] = 0;
            if (col_has(m, n, c, q)) begin
                placed = 1'b0;
                for (int g = 0; g < q; g++) begin
                    if (!placed && ld[g] == g && sz[g] < 3) begin
                        ok = 1'b1;
                        for (int s = 0; s < q; s++)
                            if (ld[s] == g && !exclusive(n, coex, s, q)) ok = 1'b0;
                        if (ok) begin
                            ld[q] = g;
                            sz[g] = sz[g] + 1;
                            placed = 1'b1;
                        end
                    end
                end
                if (!placed) begin
                    ld[q] = q;
                    sz[q] = 1;
                end
            end
        end
        r = '0;
        for (int q = 0; q < n * n; q++)
            if (ld[q] == p && ld[p] == p) r[q] = 1'b1;
        return r;
    endfunction

    function automatic int map_max(int m, int n);
        int best, s;
        best = 0;
        for (int a = 0; a < m; a++)
            for (int b = 0; b < m; b++) begin
                s = 0;
                for (int i = 0; i < n; i++)
                    for (int j = 0; j < n; j++)
                        if ((((a >> i) & 1) == 1) && (((b >> j) & 1) == 1)) s = s + wmod(m, i + j);
                if (s > best) best = s;
            end
        return best;
    endfunction

    function automatic int fold_val(int m, int n, int x);
        int r;
        r = x % (1 << n);
        for (int t = n; t < 31; t++)
            if (((x >> t) & 1) == 1) r = r + wmod(m, t);
        return r;
    endfunction

    function automatic int fold_max(int m, int n, int bound);
        int best, f;
        best = 0;
        for (int x = 0; x <= bound; x++) begin
            f = fold_val(m, n, x);
            if (f > best) best = f;
        end
        return best;
    endfunction

    // bound of the value after k folds
    function automatic int bound_after(int m, int n, int k);
        int b;
        b = map_max(m, n);
        for (int s = 0; s < k; s++) b = fold_max(m, n, b);
        return b;
    endfunction

    function automatic int fold_count(int m, int n);
        int b, cnt;
        b = map_max(m, n);
        cnt = 0;
        for (int s = 0; s < 32; s++)
            if (b >= 2 * m) begin
                b = fold_max(m, n, b);
                cnt = cnt + 1;
            end
        return cnt;
    endfunction

    function automatic int bits_for(int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/resmul_map.sv
module resmul_map
    import resmul_pkg::*;
#(
    parameter int MOD = 13,
    parameter int N   = op_width(MOD),
    parameter int W   = bits_for(map_max(MOD, N))
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [W-1:0] sum_o
);
    localparam int P = N * N;
    localparam logic [MAX_P-1:0] COEX = coex_mask(MOD, N);

    logic [P-1:0] prod;
    logic [P-1:0] grp [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            assign prod[i*N+j] = a_i[i] & b_i[j];
        end
    end

    // each column holds one OR gate per group of mutually exclusive products
    for (genvar c = 0; c < N; c++) begin : g_column
        for (genvar p = 0; p < P; p++) begin : g_grp
            localparam logic [MAX_P-1:0] MEMB = members(MOD, N, COEX, c, p);
            assign grp[c][p] = |(prod & MEMB[P-1:0]);
        end
    end

    always_comb begin
        sum_o = '0;
        for (int c = 0; c < N; c++)
            sum_o = sum_o + (W'($countones(grp[c])) << c);
    end

endmodule

// File: rtl/resmul_fold.sv
module resmul_fold
    import resmul_pkg::*;
#(
    parameter int MOD = 13,
    parameter int N   = op_width(MOD),
    parameter int WI  = 8,
    parameter int WO  = 6
) (
    input  logic [WI-1:0] x_i,
    output logic [WO-1:0] y_o
);
    logic [WO-1:0] term [WI];

    for (genvar t = 0; t < WI; t++) begin : g_term
        localparam int WT = (t < N) ? (1 << t) : wmod(MOD, t);
        assign term[t] = x_i[t] ? WO'(WT) : '0;
    end

    always_comb begin
        y_o = '0;
        for (int t = 0; t < WI; t++) y_o = y_o + term[t];
    end

endmodule

// File: rtl/resmul_fix.sv
module resmul_fix
    import resmul_pkg::*;
#(
    parameter int MOD = 13,
    parameter int N   = op_width(MOD)
) (
    input  logic [N:0]   y_i,
    output logic [N-1:0] c_o
);
    localparam logic [N:0]   MODW = (N+1)'(MOD);
    localparam logic [N-1:0] MODN = N'(MOD);

    logic ge;

    assign ge  = (y_i >= MODW);
    assign c_o = ge ? (y_i[N-1:0] - MODN) : y_i[N-1:0];

endmodule

// File: rtl/resmul_core.sv
module resmul_core
    import resmul_pkg::*;
#(
    parameter int MOD = 13,
    parameter int N   = op_width(MOD)
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] c_o
);
    localparam int NF = fold_count(MOD, N);
    localparam int W0 = bits_for(map_max(MOD, N));
    localparam int WF = bits_for(bound_after(MOD, N, NF));

    logic [W0-1:0] mapped;
    logic [N:0]    pre_fix;

    resmul_map #(.MOD(MOD), .N(N), .W(W0)) u_map (
        .a_i   (a_i),
        .b_i   (b_i),
        .sum_o (mapped)
    );

    for (genvar k = 0; k < NF; k++) begin : g_fold
        localparam int WI = bits_for(bound_after(MOD, N, k));
        localparam int WO = bits_for(bound_after(MOD, N, k + 1));
        logic [WI-1:0] x;
        logic [WO-1:0] y;
        if (k == 0) begin : g_first
            assign x = mapped;
        end else begin : g_next
            assign x = g_fold[k-1].y;
        end
        resmul_fold #(.MOD(MOD), .N(N), .WI(WI), .WO(WO)) u_fold (
            .x_i (x),
            .y_o (y)
        );
    end

    if (NF == 0) begin : g_nofold
        assign pre_fix = (N+1)'(mapped);
    end else begin : g_lastfold
        assign pre_fix = (N+1)'(g_fold[NF-1].y);
    end

    resmul_fix #(.MOD(MOD), .N(N)) u_fix (
        .y_i (pre_fix),
        .c_o (c_o)
    );

endmodule

// File: rtl/resmul_chk.sv
module resmul_chk
    import resmul_pkg::*;
#(
    parameter int MOD = 13,
    parameter int N   = op_width(MOD)
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [N-1:0] c_o
);
    localparam logic [N:0] MODV = (N+1)'(MOD);
    localparam logic [N:0] TOPV = (N+1)'(MOD - 1);

    logic legal;
    assign legal = ({1'b0, a_i} < MODV) && ({1'b0, b_i} < MODV);

    always_comb begin
        if (legal) begin
            AST_RESULT_IN_RANGE: assert ({1'b0, c_o} < MODV) else $error("c_o out of range"); // R3
            AST_RESULT_PRODUCT: assert (int'(c_o) == (int'(a_i) * int'(b_i)) % MOD) else $error("wrong product"); // R2
            if (a_i == '0 || b_i == '0) begin
                AST_ZERO_OPERAND: assert (c_o == '0) else $error("zero operand"); // R4
            end
            if (a_i == N'(1)) begin
                AST_UNIT_OPERAND: assert (c_o == b_i) else $error("unit operand"); // R5
            end
            if (MOD > 1 && {1'b0, a_i} == TOPV && {1'b0, b_i} == TOPV) begin
                AST_TOP_SQUARE: assert (c_o == N'(1)) else $error("top square"); // R7
            end
        end
    end

endmodule

bind resmul_core resmul_chk #(.MOD(MOD), .N(N)) u_chk (
    .a_i (a_i),
    .b_i (b_i),
    .c_o (c_o)
);

// File: tb/test_resmul_core.sv
module test_resmul_core;
    import resmul_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N5  = op_width(5);
    localparam int N13 = op_width(13);
    localparam int N31 = op_width(31);
    localparam int N61 = op_width(61);

    typedef struct {
        int idx;
        int m;
        int a;
        int b;
        int exp;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N5-1:0]  a5 = '0,  b5 = '0,  c5;
    logic [N13-1:0] a13 = '0, b13 = '0, c13;
    logic [N31-1:0] a31 = '0, b31 = '0, c31;
    logic [N61-1:0] a61 = '0, b61 = '0, c61;

    resmul_core #(.MOD(13)) i_resmul_core (.a_i(a13), .b_i(b13), .c_o(c13));
    resmul_core #(.MOD(5))  i_resmul_m5   (.a_i(a5),  .b_i(b5),  .c_o(c5));
    resmul_core #(.MOD(31)) i_resmul_m31  (.a_i(a31), .b_i(b31), .c_o(c31));
    resmul_core #(.MOD(61)) i_resmul_m61  (.a_i(a61), .b_i(b61), .c_o(c61));

    item_t sb [$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic int dut_out(int idx);
        case (idx)
            0: return int'(c5);
            1: return int'(c13);
            2: return int'(c31);
            default: return int'(c61);
        endcase
    endfunction

    function automatic string tag_of(item_t it);
        if (it.a == 0 || it.b == 0) return "R4";
        if (it.a == 1 || it.b == 1) return "R5";
        if (it.a == it.m - 1 && it.b == it.m - 1) return "R7";
        if (it.m == 5 && it.a == 2 && it.b == 4) return "R6";
        if (it.a == it.m - 1 || it.b == it.m - 1) return "R1";
        if (it.m == 31) return "R8";
        return "R2";
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: apply one legal pair, push the model result into the scoreboard
    task automatic drive(int idx, int m, int a, int b);
        item_t it;
        @(negedge clk);
        case (idx)
            0: begin a5  = N5'(a);  b5  = N5'(b);  end
            1: begin a13 = N13'(a); b13 = N13'(b); end
            2: begin a31 = N31'(a); b31 = N31'(b); end
            default: begin a61 = N61'(a); b61 = N61'(b); end
        endcase
        it.idx = idx; it.m = m; it.a = a; it.b = b; it.exp = (a * b) % m;
        sb.push_back(it);
    endtask

    task automatic sweep(int idx, int m);
        for (int a = 0; a < m; a++)
            for (int b = 0; b < m; b++)
                drive(idx, m, a, b);
    endtask

    // monitor: compare at the rising edge, half a period after the inputs moved
    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            int act;
            it  = sb.pop_front();
            act = dut_out(it.idx);
            check(tag_of(it), act, it.exp);
            check("R3", (act < it.m) ? 1 : 0, 1);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R4: all-zero operands give zero on every instance after start-up
        check("R4", int'(c5), 0);
        check("R4", int'(c13), 0);
        check("R4", int'(c31), 0);
        check("R4", int'(c61), 0);
        @(negedge clk);
        rst = 1'b0;
        sweep(0, 5);
        sweep(1, 13);
        sweep(2, 31);
        sweep(3, 61);
        repeat (3) @(posedge clk);
        #1;
        check("R2", sb.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule